// File: doc/BRIEF.md
# Variable-Length Bytecode Fetch Buffer

This block sits between the program-memory read port and the bytecode decoder of a virtual-machine front end. Program memory is 4 bytes wide and is always read on word-aligned addresses. Bytecodes are 2, 4, 6 or 10 bytes long. The block keeps up to 12 leftover bytes in a shift buffer. In the same cycle it merges those bytes with the word being read, then hands one complete bytecode to the decoder. It also forms the next buffer contents and the next byte count.

The first byte of the window goes to the external decoder as the opcode. The decoder answers in the same cycle with a length code. The block raises its valid output as soon as the buffered bytes plus the current read word hold the whole bytecode. A valid/ready handshake stalls delivery while the consumer is busy. A completion pulse marks each accepted bytecode, so a mode change can happen in the same cycle. A flush empties the buffer and restarts fetching at any even target address. When the target sits on a half-word, the two bytes below it in the first word are dropped.

Top module: `bytecode_fetch_buf`

## Requirements
- R1: While reset is asserted, `bc_valid_o` and `mem_req_o` are low. In the first cycle after reset is released, a read of the word at address 0 is requested.
- R2: Every requested read address has its two low bits at zero. Each read without an intervening flush is at the previous read address plus 4, and the address holds when no read is made.
- R3: A read is requested exactly when the byte count remains at 8 or fewer after the head bytecode is taken from the buffered bytes alone, and the cycle is not a flush cycle. If the head is not taken this way, the check uses the full count. The count never exceeds 12 and is always even.
- R4: An accepted bytecode presents its bytes in program order, little-endian, on `bc_data_o`. Byte 0 (bits 7:0) is the opcode at the lowest address. Bytes at or beyond the length are zero. `bc_pc_o` is the address of byte 0. Successive bytecodes come from consecutive addresses.
- R5: `op_o` shows the head opcode. The length code on `len_i` is decoded as 0 → 2 bytes, 1 → 4 bytes, 2 → 6 bytes, 3 → 10 bytes.
- R6: `bc_valid_o` is high in exactly the cycles where the buffered bytes plus the bytes supplied by this cycle's read reach the head length. After an aligned flush, a 2- or 4-byte bytecode is valid in the first cycle. A steady run of 2-byte or of 4-byte bytecodes with ready held high is delivered one per cycle.
- R7: From an empty buffer at an aligned target, a 6-byte bytecode becomes valid in the second cycle and a 10-byte bytecode in the third. A 6-byte stream delivers 20 bytecodes in 30 cycles, and a 10-byte stream delivers 12 in 30 cycles.
- R8: While `flush_i` is high, no read is requested and `bc_valid_o` and `bc_done_o` are low. The next read is at the word holding the target, and the next bytecode delivered has `bc_pc_o` equal to the target.
- R9: For a target with bit 1 set, the first word supplies only its upper two bytes. A 2-byte bytecode there is valid in the first cycle, 4- and 6-byte ones in the second, and a 10-byte one in the third.
- R10: When valid is high and ready is low, the next cycle (unless it flushes) still has valid high with unchanged `bc_data_o` and `bc_pc_o`.
- R11: `bc_done_o` is high exactly in the cycles where valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty the buffer and restart at `flush_pc_i` |
| flush_pc_i | input | ADDR_W | Restart byte address (even) |
| mem_req_o | output | 1 | Program-memory read request this cycle |
| mem_addr_o | output | ADDR_W | Word-aligned read byte address |
| mem_rdata_i | input | 32 | Read data, same cycle, byte 0 in bits 7:0 |
| op_o | output | 8 | Head opcode byte for the decoder |
| len_i | input | 2 | Length code returned by the decoder |
| bc_valid_o | output | 1 | Complete bytecode available |
| bc_ready_i | input | 1 | Consumer accepts the bytecode |
| bc_data_o | output | 80 | Bytecode bytes, little-endian, zero-padded |
| bc_pc_o | output | ADDR_W | Address of the presented bytecode |
| bc_done_o | output | 1 | Bytecode accepted this cycle |

## Verification
Each of the four lengths is run from aligned and half-word restart targets. These runs separate the one-, two- and three-cycle completion paths and show the dropped lower bytes. Uniform streams of each length under constant ready pin down throughput, which tells apart a refill rule based on occupancy after consumption from one based on occupancy before it. A mixed-length stream with an irregular ready pattern and a flush in mid-stream checks ordering, stall hold, and restart. Throughout all runs, a cycle-by-cycle occupancy model in the bench predicts every read request and every valid cycle.

// File: rtl/bcf_pkg.sv
package bcf_pkg;

  localparam int unsigned WORD_BYTES   = 4;
  localparam int unsigned MAX_BC_BYTES = 10;

  typedef enum logic [1:0] {
    LEN_2B  = 2'd0,
    LEN_4B  = 2'd1,
    LEN_6B  = 2'd2,
    LEN_10B = 2'd3
  } len_code_e;

  // Byte count of a bytecode for a given length code.
  function automatic logic [3:0] len_bytes(input len_code_e code);
    case (code)
      LEN_2B:  return 4'd2;
      LEN_4B:  return 4'd4;
      LEN_6B:  return 4'd6;
      default: return 4'd10;
    endcase
  endfunction

  // Drop the lower half-word of a read when the fetch started mid-word.
  function automatic logic [31:0] align_word(input logic [31:0] word, input logic skip_low);
    return skip_low ? {16'h0000, word[31:16]} : word;
  endfunction

  // Number of useful bytes a read contributes.
  function automatic logic [2:0] word_yield(input logic rd, input logic skip_low);
    if (!rd) return 3'd0;
    return skip_low ? 3'd2 : 3'd4;
  endfunction

endpackage

// File: rtl/bcf_addr_ctrl.sv
module bcf_addr_ctrl
  import bcf_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_pc_i,
  input  logic              rd_en_i,
  input  logic [3:0]        take_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic              skip_o,
  output logic [ADDR_W-1:0] head_pc_o
);

  localparam int unsigned WA_W = ADDR_W - 2;

  logic [WA_W-1:0]   waddr_q;
  logic              skip_q;
  logic [ADDR_W-1:0] head_q;
  logic [ADDR_W-1:0] target;

  assign target = flush_pc_i & ~ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= RESET_PC[ADDR_W-1:2];
      skip_q  <= RESET_PC[1];
      head_q  <= RESET_PC & ~ADDR_W'(1);
    end else if (flush_i) begin
      waddr_q <= target[ADDR_W-1:2];
      skip_q  <= target[1];
      head_q  <= target;
    end else begin
      if (rd_en_i) begin
        waddr_q <= waddr_q + WA_W'(1);
        skip_q  <= 1'b0;
      end
      head_q <= head_q + ADDR_W'(take_i);
    end
  end

  assign word_addr_o = {waddr_q, 2'b00};
  assign skip_o      = skip_q;
  assign head_pc_o   = head_q;

endmodule

// File: rtl/bcf_merge.sv
module bcf_merge
  import bcf_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 12,
  parameter int unsigned CNT_W     = 5
) (
  input  logic [8*BUF_BYTES-1:0]              buf_i,
  input  logic [CNT_W-1:0]                    occ_i,
  input  logic [31:0]                         rdata_i,
  input  logic                                rd_en_i,
  input  logic                                skip_i,
  output logic [8*(BUF_BYTES+WORD_BYTES)-1:0] win_o,
  output logic [CNT_W-1:0]                    avail_o,
  output logic [7:0]                          op_o
);

  localparam int unsigned WIN_W = 8 * (BUF_BYTES + WORD_BYTES);

  logic [31:0]      fresh;
  logic [WIN_W-1:0] fresh_ext;
  logic [WIN_W-1:0] buf_ext;

  assign fresh     = align_word(rdata_i, skip_i);
  assign buf_ext   = WIN_W'(buf_i);
  assign fresh_ext = rd_en_i ? (WIN_W'(fresh) << {occ_i, 3'b000}) : '0;

  // Buffered bytes above the count are held at zero, so OR merges cleanly.
  assign win_o   = buf_ext | fresh_ext;
  assign avail_o = occ_i + CNT_W'(word_yield(rd_en_i, skip_i));

  // Opcode path is independent of the read enable so the decoder reply
  // can feed the refill decision without a loop.
  assign op_o = (occ_i != '0) ? buf_i[7:0] : fresh[7:0];

endmodule

// File: rtl/bcf_shift_buf.sv
module bcf_shift_buf
  import bcf_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 12,
  parameter int unsigned CNT_W     = 5
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                clear_i,
  input  logic [8*(BUF_BYTES+WORD_BYTES)-1:0] win_i,
  input  logic [CNT_W-1:0]                    avail_i,
  input  logic [3:0]                          take_i,
  output logic [8*BUF_BYTES-1:0]              buf_o,
  output logic [CNT_W-1:0]                    occ_o
);

  localparam int unsigned WIN_W = 8 * (BUF_BYTES + WORD_BYTES);

  logic [WIN_W-1:0]       shifted;
  logic [8*BUF_BYTES-1:0] buf_q;
  logic [CNT_W-1:0]       occ_q;

  assign shifted = win_i >> {take_i, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      occ_q <= '0;
    end else if (clear_i) begin
      buf_q <= '0;
      occ_q <= '0;
    end else begin
      buf_q <= shifted[8*BUF_BYTES-1:0];
      occ_q <= avail_i - CNT_W'(take_i);
    end
  end

  assign buf_o = buf_q;
  assign occ_o = occ_q;

endmodule

// File: rtl/bytecode_fetch_buf.sv
module bytecode_fetch_buf
  import bcf_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       BUF_BYTES = 12,
  parameter logic [ADDR_W-1:0] RESET_PC  = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush_i,
  input  logic [ADDR_W-1:0]         flush_pc_i,
  output logic                      mem_req_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  input  logic [31:0]               mem_rdata_i,
  output logic [7:0]                op_o,
  input  logic [1:0]                len_i,
  output logic                      bc_valid_o,
  input  logic                      bc_ready_i,
  output logic [8*MAX_BC_BYTES-1:0] bc_data_o,
  output logic [ADDR_W-1:0]         bc_pc_o,
  output logic                      bc_done_o
);

  localparam int unsigned WIN_BYTES  = BUF_BYTES + WORD_BYTES;
  localparam int unsigned WIN_W      = 8 * WIN_BYTES;
  localparam int unsigned CNT_W      = $clog2(WIN_BYTES + 1);
  localparam int unsigned REFILL_MAX = BUF_BYTES - WORD_BYTES;

  // Named internal events used by the bound checker.
  logic [8*BUF_BYTES-1:0] buf_q;
  logic [CNT_W-1:0]       occ;
  logic [WIN_W-1:0]       win;
  logic [CNT_W-1:0]       avail;
  logic                   skip;
  logic [ADDR_W-1:0]      head_pc;
  logic [3:0]             lenb;
  logic                   act;
  logic                   head_in_buf;
  logic [CNT_W-1:0]       occ_left;
  logic                   rd_en;
  logic                   valid;
  logic                   fire;
  logic [3:0]             take;

  always_comb begin
    act         = rst_n && !flush_i;
    lenb        = len_bytes(len_code_e'(len_i));
    head_in_buf = occ >= CNT_W'(lenb);
    occ_left    = occ - ((head_in_buf && bc_ready_i) ? CNT_W'(lenb) : '0);
    rd_en       = act && (occ_left <= CNT_W'(REFILL_MAX));
    valid       = act && (avail >= CNT_W'(lenb));
    fire        = valid && bc_ready_i;
    take        = fire ? lenb : 4'd0;
  end

  bcf_addr_ctrl #(
    .ADDR_W  (ADDR_W),
    .RESET_PC(RESET_PC)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .flush_pc_i (flush_pc_i),
    .rd_en_i    (rd_en),
    .take_i     (take),
    .word_addr_o(mem_addr_o),
    .skip_o     (skip),
    .head_pc_o  (head_pc)
  );

  bcf_merge #(
    .BUF_BYTES(BUF_BYTES),
    .CNT_W    (CNT_W)
  ) u_merge (
    .buf_i  (buf_q),
    .occ_i  (occ),
    .rdata_i(mem_rdata_i),
    .rd_en_i(rd_en),
    .skip_i (skip),
    .win_o  (win),
    .avail_o(avail),
    .op_o   (op_o)
  );

  bcf_shift_buf #(
    .BUF_BYTES(BUF_BYTES),
    .CNT_W    (CNT_W)
  ) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(flush_i),
    .win_i  (win),
    .avail_i(avail),
    .take_i (take),
    .buf_o  (buf_q),
    .occ_o  (occ)
  );

  for (genvar gi = 0; gi < MAX_BC_BYTES; gi++) begin : g_out_byte
    assign bc_data_o[8*gi +: 8] = (4'(gi) < lenb) ? win[8*gi +: 8] : 8'h00;
  end

  assign mem_req_o  = rd_en;
  assign bc_valid_o = valid;
  assign bc_pc_o    = head_pc;
  assign bc_done_o  = fire;

endmodule

// File: rtl/bytecode_fetch_buf_chk.sv
module bytecode_fetch_buf_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BUF_BYTES = 12,
  parameter int unsigned CNT_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_i,
  input logic [ADDR_W-1:0] flush_pc_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              bc_valid_o,
  input logic              bc_ready_i,
  input logic [79:0]       bc_data_o,
  input logic [ADDR_W-1:0] bc_pc_o,
  input logic              bc_done_o,
  input logic [CNT_W-1:0]  occ
);

  localparam int unsigned LOW_MARK = BUF_BYTES - 4;

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !flush_i) |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(4)));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_o && !flush_i) |=> $stable(mem_addr_o));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ <= CNT_W'(BUF_BYTES)) && (occ[0] == 1'b0));

  assert_refill_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && occ <= CNT_W'(LOW_MARK)) |-> mem_req_o);

  assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> (!mem_req_o && !bc_valid_o && !bc_done_o));

  assert_flush_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> ((mem_addr_o[ADDR_W-1:2] == $past(flush_pc_i[ADDR_W-1:2])) &&
                 (bc_pc_o[ADDR_W-1:1] == $past(flush_pc_i[ADDR_W-1:1])) &&
                 (occ == '0)));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid_o && !bc_ready_i && !flush_i) |=>
      (flush_i || (bc_valid_o && $stable(bc_data_o) && $stable(bc_pc_o))));

  assert_done_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_done_o && !flush_i) |=> (flush_i || (bc_pc_o != $past(bc_pc_o))));

endmodule

bind bytecode_fetch_buf bytecode_fetch_buf_chk #(
  .ADDR_W   (ADDR_W),
  .BUF_BYTES(BUF_BYTES),
  .CNT_W    (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush_i   (flush_i),
  .flush_pc_i(flush_pc_i),
  .mem_req_o (mem_req_o),
  .mem_addr_o(mem_addr_o),
  .bc_valid_o(bc_valid_o),
  .bc_ready_i(bc_ready_i),
  .bc_data_o (bc_data_o),
  .bc_pc_o   (bc_pc_o),
  .bc_done_o (bc_done_o),
  .occ       (occ)
);

// File: tb/bytecode_fetch_buf_bench.sv
module bytecode_fetch_buf_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [15:0] flush_pc = 16'h0;
  logic        ready = 1'b0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata;
  logic [7:0]  op;
  logic [1:0]  len_code;
  logic        valid;
  logic [79:0] data;
  logic [15:0] pc;
  logic        done;

  logic [7:0] pmem [0:255];

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  always_comb begin
    mem_rdata = {pmem[{mem_addr[7:2], 2'd3}], pmem[{mem_addr[7:2], 2'd2}],
                 pmem[{mem_addr[7:2], 2'd1}], pmem[{mem_addr[7:2], 2'd0}]};
  end

  // External decoder: length code carried in the top two opcode bits.
  assign len_code = op[7:6];

  bytecode_fetch_buf u_bytecode_fetch_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush),
    .flush_pc_i (flush_pc),
    .mem_req_o  (mem_req),
    .mem_addr_o (mem_addr),
    .mem_rdata_i(mem_rdata),
    .op_o       (op),
    .len_i      (len_code),
    .bc_valid_o (valid),
    .bc_ready_i (ready),
    .bc_data_o  (data),
    .bc_pc_o    (pc),
    .bc_done_o  (done)
  );

  function automatic int blen(input logic [1:0] c);
    case (c)
      2'd0: return 2;
      2'd1: return 4;
      2'd2: return 6;
      default: return 10;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Stream of bytecodes laid out from tgt; kind 0..3 fixed length, 4 mixed.
  task automatic fill(input int kind, input int tgt);
    int a;
    int s;
    logic [1:0] lc;
    a = tgt;
    s = 0;
    while (a < tgt + 200) begin
      case (kind)
        0, 1, 2, 3: lc = 2'(kind);
        default: begin
          case (s % 4)
            0: lc = 2'd3;
            1: lc = 2'd0;
            2: lc = 2'd2;
            default: lc = 2'd1;
          endcase
        end
      endcase
      pmem[a & 255] = {lc, 6'(s)};
      for (int k = 1; k < blen(lc); k++) pmem[(a + k) & 255] = 8'((a + k) * 37 + 5);
      a = a + blen(lc);
      s++;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic restart(input logic [15:0] tgt, input int kind);
    tick();
    flush    = 1'b1;
    flush_pc = tgt;
    fill(kind, int'(tgt));
    tick();
    flush = 1'b0;
  endtask

  // ---------------- cycle monitor with occupancy model ----------------
  logic [15:0] exp_pc;
  int          m_occ;
  bit          m_skip;
  bit          have_last;
  logic [15:0] last_addr;
  bit          prev_stall;
  logic [79:0] prev_data;
  logic [15:0] prev_pc;

  always @(negedge clk) begin : mon
    int L;
    int fresh;
    bit cons;
    bit e_req;
    bit e_valid;
    logic [79:0] e_data;
    if (!rst_n) begin
      exp_pc     = 16'h0;
      m_occ      = 0;
      m_skip     = 1'b0;
      have_last  = 1'b0;
      prev_stall = 1'b0;
    end else if (flush) begin
      check(!mem_req && !valid && !done, "R8", "quiet during flush",
            {mem_req, valid, done}, 3'b000);
      exp_pc     = flush_pc & 16'hFFFE;
      m_occ      = 0;
      m_skip     = flush_pc[1];
      have_last  = 1'b0;
      prev_stall = 1'b0;
    end else begin
      L     = blen(pmem[exp_pc[7:0]][7:6]);
      cons  = (m_occ >= L) && ready;
      e_req = (m_occ - (cons ? L : 0)) <= 8;
      check(mem_req == e_req, "R3", "read request", mem_req, e_req);
      fresh   = mem_req ? (m_skip ? 2 : 4) : 0;
      e_valid = (m_occ + fresh) >= L;
      check(valid == e_valid, "R6", "valid timing", valid, e_valid);
      check(done == (valid && ready), "R11", "done pulse", done, valid && ready);
      if (mem_req) begin
        check(mem_addr[1:0] == 2'b00, "R2", "aligned address", mem_addr, {mem_addr[15:2], 2'b00});
        if (have_last)
          check(mem_addr == last_addr + 16'd4, "R2", "address step", mem_addr, last_addr + 16'd4);
        have_last = 1'b1;
        last_addr = mem_addr;
      end
      if (prev_stall)
        check(valid && data == prev_data && pc == prev_pc, "R10", "stall hold", {valid, pc}, {1'b1, prev_pc});
      if (done) begin
        check(pc == exp_pc, "R4", "bytecode address", pc, exp_pc);
        for (int k = 0; k < 10; k++)
          e_data[8*k +: 8] = (k < L) ? pmem[(int'(exp_pc) + k) & 255] : 8'h00;
        check(data == e_data, "R4", "bytecode bytes", data, e_data);
        check(op == pmem[exp_pc[7:0]], "R5", "opcode byte", op, pmem[exp_pc[7:0]]);
        exp_pc = exp_pc + 16'(L);
      end
      m_occ      = m_occ + fresh - (done ? L : 0);
      if (mem_req) m_skip = 1'b0;
      prev_stall = valid && !ready;
      prev_data  = data;
      prev_pc    = pc;
    end
  end

  // ---------------- scenarios ----------------
  task automatic t_reset();
    fill(1, 0);
    ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!valid && !mem_req, "R1", "quiet in reset", {valid, mem_req}, 2'b00);
    end
    tick();
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_req && mem_addr == 16'h0, "R1", "first read after reset", {mem_req, mem_addr}, {1'b1, 16'h0});
  endtask

  task automatic t_latency(input int kind, input logic [15:0] tgt, input int exp_n, input string req);
    int n;
    ready = 1'b1;
    restart(tgt, kind);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1)
        check(mem_req && mem_addr == (tgt & 16'hFFFC), "R8", "restart word", mem_addr, tgt & 16'hFFFC);
    end while (!done && n < 12);
    check(n == exp_n, req, "cycles to first bytecode", n, exp_n);
    check(pc == tgt, "R8", "first pc after flush", pc, tgt);
  endtask

  task automatic t_rate(input int kind, input int cycles, input int exp_n, input string req);
    int n;
    ready = 1'b1;
    restart(16'h0040, kind);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (done) n++;
    end
    check(n == exp_n, req, "bytecodes delivered", n, exp_n);
  endtask

  task automatic t_stall_full();
    ready = 1'b0;
    restart(16'h0020, 1);
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (i >= 4)
        check(!mem_req && valid, "R3", "no read with full buffer", {mem_req, valid}, 2'b01);
    end
    check(pc == 16'h0020, "R10", "held pc", pc, 16'h0020);
    tick();
    ready = 1'b1;
    @(negedge clk);
    check(done && pc == 16'h0020, "R11", "accept after stall", {done, pc}, {1'b1, 16'h0020});
  endtask

  task automatic t_mixed(input int cycles);
    int n;
    ready = 1'b0;
    restart(16'h0010, 4);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      ready = ((i % 3) != 0) || ((i % 7) == 3);
      @(negedge clk);
      if (done) n++;
      tick();
    end
    check(n >= 10, "R4", "mixed stream progress", n, 10);
  endtask

  initial begin : main
    t_reset();
    t_latency(0, 16'h0000, 1, "R6");
    t_latency(1, 16'h0000, 1, "R6");
    t_latency(2, 16'h0000, 2, "R7");
    t_latency(3, 16'h0000, 3, "R7");
    t_latency(0, 16'h0002, 1, "R9");
    t_latency(1, 16'h0002, 2, "R9");
    t_latency(2, 16'h0006, 2, "R9");
    t_latency(3, 16'h000A, 3, "R9");
    t_rate(0, 20, 20, "R6");
    t_rate(1, 20, 20, "R6");
    t_rate(2, 30, 20, "R7");
    t_rate(3, 30, 12, "R7");
    t_stall_full();
    t_mixed(60);
    t_latency(3, 16'h0032, 3, "R8");
    t_mixed(40);
    tick();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule